// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two 16-bit buses, called A and B, in two 8-bit groups that are controlled separately. In each group, each transfer direction (A toward B and B toward A) has three controls: an output enable, a source select and a capture clock. When a direction is enabled, it drives its destination bus. The data is either the present value of the opposite bus (live) or the contents of a storage register (stored). The A storage register samples the A bus and the B storage register samples the B bus, each on a rising edge of its own capture clock.

Each bus is a set of separate vectors: data in, data out and a per-bit output enable. An all-zero output enable stands for high impedance. The capture clocks are ordinary inputs sampled on the system clock, and a capture happens when a capture input is low in one cycle and high in the next. If both directions of a group are enabled in live mode, each bus output follows the opposite bus. The outside bus model then closes the loop, and both buses keep their last value once every external driver lets go.

Top module: `regd_bus_xcvr`

## Requirements
- R1: An active-low asynchronous reset clears both storage registers of every group. Selecting stored data (select = 1) right after reset drives zero.
- R2: When a direction's enable bit is 0, the destination bus output enable and data out are all zero for that group. The A to B enable controls `b_oe`/`b_out` and the B to A enable controls `a_oe`/`a_out`.
- R3: With the A to B enable at 1 and the A to B select at 0 (live), `b_out` of that group equals `a_in` of the same cycle, and `b_oe` is all ones.
- R4: With the B to A enable at 1 and the B to A select at 0 (live), `a_out` of that group equals `b_in` of the same cycle, and `a_oe` is all ones.
- R5: A rising edge of the A capture input loads `a_in` into the A register. A rising edge is a 0 in one clock cycle followed by a 1 in the next. Once loaded, the value is driven on `b_out` when select = 1, and it does not change if `a_in` changes later.
- R6: A rising edge of the B capture input loads `b_in` into the B register. The value is driven on `a_out` when select = 1, and it does not change if `b_in` changes later.
- R7: A capture takes place whatever the values of the enables and selects. A value captured while the direction is disabled appears once the direction is enabled with select = 1.
- R8: Holding a capture input high for several cycles causes exactly one capture, on the cycle where it went from 0 to 1.
- R9: Group g covers bus bits [8g+7:8g] and uses control bit g. Controls and captures in one group have no effect on the other group's outputs.
- R10: With both enables at 1 and both selects at 0 in a group, the outputs mirror the opposite inputs. A bus model that keeps its last resolved value then holds both buses at the last driven value after all external drivers are released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 16 | Resolved value of the A bus |
| a_out | output | 16 | Data driven onto the A bus |
| a_oe | output | 16 | Per-bit drive enable for the A bus |
| b_in | input | 16 | Resolved value of the B bus |
| b_out | output | 16 | Data driven onto the B bus |
| b_oe | output | 16 | Per-bit drive enable for the B bus |
| ab_en | input | 2 | Per-group enable, A to B direction |
| ba_en | input | 2 | Per-group enable, B to A direction |
| ab_sel | input | 2 | Per-group source for B bus: 0 live, 1 stored |
| ba_sel | input | 2 | Per-group source for A bus: 0 live, 1 stored |
| ab_cap | input | 2 | Per-group capture input of the A register |
| ba_cap | input | 2 | Per-group capture input of the B register |

## Verification
Live transfer is driven with two unrelated 16-bit patterns in each direction. A stuck or swapped bit therefore shows up, as does a wrong group mapping. Stored replay changes the source bus after capture, which separates a real register from a live pass-through. A capture input held high across further bus changes separates edge detection from level sensing. Capture is also run with the direction disabled and with only one group's capture input toggled, to show independence from the controls and between groups. Finally, the dual-enable live case is run with the external drivers released, to show the loop keeps the value.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
   typedef enum logic {
      SRC_LIVE   = 1'b0,
      SRC_STORED = 1'b1
   } src_sel_e;

   function automatic logic [63:0] pick_src(input logic stored,
                                            input logic [63:0] live_v,
                                            input logic [63:0] kept_v);
      return (src_sel_e'(stored) == SRC_STORED) ? kept_v : live_v;
   endfunction
endpackage

// File: rtl/xcvr_edge.sv
module xcvr_edge #(
   parameter int N = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl,
   output logic [N-1:0] rise
);
   logic [N-1:0] lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= '0;
      else        lvl_q <= lvl;
   end

   assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/xcvr_store.sv
module xcvr_store #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= d;
   end
endmodule

// File: rtl/xcvr_group.sv
module xcvr_group
   import xcvr_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] a_in,
   input  logic [W-1:0] b_in,
   input  logic         ab_en,
   input  logic         ba_en,
   input  logic         ab_sel,
   input  logic         ba_sel,
   input  logic         ab_cap,
   input  logic         ba_cap,
   output logic [W-1:0] a_out,
   output logic [W-1:0] a_oe,
   output logic [W-1:0] b_out,
   output logic [W-1:0] b_oe
);
   logic [1:0]   rise;
   logic [W-1:0] a_reg, b_reg;
   logic [W-1:0] to_b, to_a;
   logic [63:0]  to_b_w, to_a_w;

   xcvr_edge #(.N(2)) u_edge (
      .clk(clk), .rst_n(rst_n), .lvl({ba_cap, ab_cap}), .rise(rise)
   );

   xcvr_store #(.W(W)) u_areg (
      .clk(clk), .rst_n(rst_n), .load(rise[0]), .d(a_in), .q(a_reg)
   );

   xcvr_store #(.W(W)) u_breg (
      .clk(clk), .rst_n(rst_n), .load(rise[1]), .d(b_in), .q(b_reg)
   );

   assign to_b_w = pick_src(ab_sel, 64'(a_in), 64'(a_reg));
   assign to_a_w = pick_src(ba_sel, 64'(b_in), 64'(b_reg));
   assign to_b   = to_b_w[W-1:0];
   assign to_a   = to_a_w[W-1:0];

   assign b_oe  = {W{ab_en}};
   assign a_oe  = {W{ba_en}};
   assign b_out = ab_en ? to_b : '0;
   assign a_out = ba_en ? to_a : '0;

   // R2: a disabled direction leaves its bus undriven
   a_r2_quiet_b: assert property (@(posedge clk) disable iff (!rst_n)
      !ab_en |-> (b_oe == '0 && b_out == '0));
   a_r2_quiet_a: assert property (@(posedge clk) disable iff (!rst_n)
      !ba_en |-> (a_oe == '0 && a_out == '0));
   // R3, R4: live paths follow the opposite bus
   a_r3_live_ab: assert property (@(posedge clk) disable iff (!rst_n)
      (ab_en && !ab_sel) |-> (b_out == a_in && b_oe == '1));
   a_r4_live_ba: assert property (@(posedge clk) disable iff (!rst_n)
      (ba_en && !ba_sel) |-> (a_out == b_in && a_oe == '1));
   // R5, R6: a capture edge is replayed on the next cycle
   a_r5_replay_a: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ab_cap) ##1 (ab_en && ab_sel) |-> b_out == $past(a_in));
   a_r6_replay_b: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ba_cap) ##1 (ba_en && ba_sel) |-> a_out == $past(b_in));
   // R8: no new level change, no new stored value
   a_r8_steady_a: assert property (@(posedge clk) disable iff (!rst_n)
      (ab_en && ab_sel && !$rose(ab_cap)) ##1 (ab_en && ab_sel) |-> $stable(b_out));
endmodule

// File: rtl/regd_bus_xcvr.sv
module regd_bus_xcvr #(
   parameter int GROUPS  = 2,
   parameter int GROUP_W = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [GROUPS*GROUP_W-1:0]   a_in,
   output logic [GROUPS*GROUP_W-1:0]   a_out,
   output logic [GROUPS*GROUP_W-1:0]   a_oe,
   input  logic [GROUPS*GROUP_W-1:0]   b_in,
   output logic [GROUPS*GROUP_W-1:0]   b_out,
   output logic [GROUPS*GROUP_W-1:0]   b_oe,
   input  logic [GROUPS-1:0]           ab_en,
   input  logic [GROUPS-1:0]           ba_en,
   input  logic [GROUPS-1:0]           ab_sel,
   input  logic [GROUPS-1:0]           ba_sel,
   input  logic [GROUPS-1:0]           ab_cap,
   input  logic [GROUPS-1:0]           ba_cap
);
   localparam int BUS_W = GROUPS * GROUP_W;

   if (GROUPS < 1)                 begin : g_bad_groups $error("GROUPS must be at least 1"); end
   if (GROUP_W < 1 || GROUP_W > 64) begin : g_bad_width  $error("GROUP_W must be 1..64");    end
   if (BUS_W > 4096)               begin : g_bad_bus    $error("bus too wide");            end

   for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      xcvr_group #(.W(GROUP_W)) u_grp (
         .clk   (clk),
         .rst_n (rst_n),
         .a_in  (a_in [g*GROUP_W +: GROUP_W]),
         .b_in  (b_in [g*GROUP_W +: GROUP_W]),
         .ab_en (ab_en[g]),
         .ba_en (ba_en[g]),
         .ab_sel(ab_sel[g]),
         .ba_sel(ba_sel[g]),
         .ab_cap(ab_cap[g]),
         .ba_cap(ba_cap[g]),
         .a_out (a_out[g*GROUP_W +: GROUP_W]),
         .a_oe  (a_oe [g*GROUP_W +: GROUP_W]),
         .b_out (b_out[g*GROUP_W +: GROUP_W]),
         .b_oe  (b_oe [g*GROUP_W +: GROUP_W])
      );

      // R10: dual live enable makes each side mirror the other
      a_r10_loop: assert property (@(posedge clk) disable iff (!rst_n)
         (ab_en[g] && ba_en[g] && !ab_sel[g] && !ba_sel[g]) |->
         (b_out[g*GROUP_W +: GROUP_W] == a_in[g*GROUP_W +: GROUP_W] &&
          a_out[g*GROUP_W +: GROUP_W] == b_in[g*GROUP_W +: GROUP_W]));
   end
endmodule

// File: tb/regd_bus_xcvr_test.sv
module regd_bus_xcvr_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] a_in, b_in, a_out, a_oe, b_out, b_oe;
   logic [1:0]  ab_en = '0, ba_en = '0, ab_sel = '0, ba_sel = '0, ab_cap = '0, ba_cap = '0;
   logic        a_drv = 1'b0, b_drv = 1'b0;
   logic [15:0] a_ext = '0, b_ext = '0, a_keep = '0, b_keep = '0;
   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   // bus model: external driver wins, otherwise the bus keeps its last resolved value
   assign a_in = a_drv ? a_ext : a_keep;
   assign b_in = b_drv ? b_ext : b_keep;
   always @(posedge clk) begin
      a_keep <= a_drv ? a_ext : ((a_out & a_oe) | (a_keep & ~a_oe));
      b_keep <= b_drv ? b_ext : ((b_out & b_oe) | (b_keep & ~b_oe));
   end

   regd_bus_xcvr uut (
      .clk(clk), .rst_n(rst_n),
      .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
      .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
      .ab_en(ab_en), .ba_en(ba_en), .ab_sel(ab_sel), .ba_sel(ba_sel),
      .ab_cap(ab_cap), .ba_cap(ba_cap)
   );

   task automatic step(int n = 1);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic t_reset();
      chk("R2 a_oe after reset", a_oe, 16'h0);
      chk("R2 b_out after reset", b_out, 16'h0);
      ab_en = 2'b11; ba_en = 2'b11; ab_sel = 2'b11; ba_sel = 2'b11;
      step();
      chk("R1 A register cleared", b_out, 16'h0);
      chk("R1 B register cleared", a_out, 16'h0);
      ab_en = '0; ba_en = '0; ab_sel = '0; ba_sel = '0;
   endtask

   task automatic t_live();
      a_drv = 1; b_drv = 1; ab_en = 2'b11;
      a_ext = 16'h3C96; step();
      chk("R3 live A to B p1", b_out, 16'h3C96);
      chk("R3 b_oe driven", b_oe, 16'hFFFF);
      a_ext = 16'hE107; step();
      chk("R3 live A to B p2", b_out, 16'hE107);
      ab_en = '0; ba_en = 2'b11;
      b_ext = 16'h5AC3; step();
      chk("R4 live B to A p1", a_out, 16'h5AC3);
      chk("R2 b side released", b_oe, 16'h0);
      b_ext = 16'h0FF1; step();
      chk("R4 live B to A p2", a_out, 16'h0FF1);
      ba_en = '0;
   endtask

   task automatic t_store();
      a_ext = 16'hA55A; b_ext = 16'h1E2D; ab_cap = 2'b11; ba_cap = 2'b11; step();
      ab_cap = '0; ba_cap = '0; a_ext = 16'h1234; b_ext = 16'h4321;
      ab_en = 2'b11; ab_sel = 2'b11; ba_en = 2'b11; ba_sel = 2'b11; step();
      chk("R5 A stored replay", b_out, 16'hA55A);
      chk("R6 B stored replay", a_out, 16'h1E2D);
      // held-high capture input: one capture only
      ab_cap = 2'b11; a_ext = 16'h7788; step();
      a_ext = 16'h99AA; step(3);
      chk("R8 single capture while held high", b_out, 16'h7788);
      ab_cap = '0; step();
      ab_en = '0; ba_en = '0; ab_sel = '0; ba_sel = '0;
   endtask

   task automatic t_disabled_capture();
      a_ext = 16'h0F0F; ab_cap = 2'b11; step();
      chk("R7 disabled during capture", b_oe, 16'h0);
      ab_cap = '0; a_ext = 16'hFFFF; step();
      ab_en = 2'b11; ab_sel = 2'b11; step();
      chk("R7 captured while disabled", b_out, 16'h0F0F);
   endtask

   task automatic t_groups();
      // group 1 captures only; group 0 register keeps 0F
      a_ext = 16'hC3BE; ab_cap = 2'b10; step();
      ab_cap = '0; step();
      chk("R9 group capture isolated", b_out, 16'hC30F);
      ab_sel = 2'b10; a_ext = 16'h4466; step();
      chk("R9 mixed live and stored", b_out, 16'hC366);
      ab_en = 2'b01; step();
      chk("R9 per-group enable", b_oe, 16'h00FF);
      ab_en = '0; ab_sel = '0;
   endtask

   task automatic t_keeper();
      ab_en = 2'b11; ba_en = 2'b11; ab_sel = '0; ba_sel = '0;
      b_drv = 0; a_drv = 1; a_ext = 16'h6B94; step(2);
      chk("R10 B follows driven A", b_out, 16'h6B94);
      a_drv = 0; a_ext = 16'h0000; step(4);
      chk("R10 A bus retained", a_in, 16'h6B94);
      chk("R10 B bus retained", b_in, 16'h6B94);
      chk("R10 A output reinforces", a_out, 16'h6B94);
   endtask

   initial begin
      step(2);
      rst_n = 1'b1;
      step();
      t_reset();
      t_live();
      t_store();
      t_disabled_capture();
      t_groups();
      t_keeper();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule